// File: doc/BRIEF.md
# Dual-Rate Serial Flash Read Port

This block is the device side of a small serial flash memory, seen from the four-wire SPI bus. A host selects the device with an active-low select, shifts an 8-bit command and a 24-bit byte address into it, and receives a stream of bytes from an internal byte array. Three read commands are decoded. A plain read returns one bit per clock on the output pin. A fast dual-output read takes its address on one pin and returns two bits per clock. A dual-I/O read takes both its address and a mode byte two bits per clock, then also returns two bits per clock. In both dual commands the two data pins serve as a bidirectional pair, so each pin is brought out as separate input, output and output-enable signals.

All bus pins are sampled by the system clock through a synchronizer, and edges of the serial clock are detected in the system clock domain. The serial clock must therefore stay high and stay low for at least four system clocks in each phase. A preload port writes the array from the system side. The array holds 2^ADDR_W bytes. Address bits above that range are ignored, and a continuous read wraps from the last byte back to byte 0.

Top module: `fsp_flash_if`

## Requirements
- R1: After reset, and from at most SYNC_STAGES+2 system clocks after `spi_cs_n` goes high, both `io0_oe` and `io1_oe` are low and the next selection starts a new command.
- R2: Opcode 03h is shifted MSB first on `io0_i` and sampled on rising `spi_sclk`. A 24-bit address follows, MSB first on `io0_i`. From the next falling edge on, the addressed byte appears on `io1_o`, MSB first, one bit per falling edge. During this output `io1_oe` is 1 and `io0_oe` is 0.
- R3: Opcode 3Bh takes a 24-bit address on `io0_i` and then 8 dummy rising edges, during which both output enables stay low. It then drives two bits per falling edge with both enables high. `io1_o` carries bit 7 and `io0_o` carries bit 6, then bits 5 and 4, and so on.
- R4: Opcode BBh takes its address two bits per rising edge over 12 edges, with `io1_i` as the higher bit and the MSB pair first. An 8-bit mode byte follows over 4 edges and is ignored. Both enables stay low for all of this input. Data then follows in the R3 dual format.
- R5: A read continues through consecutive addresses for as long as the device stays selected. After address 2^ADDR_W-1 the address wraps to 0. Address bits at position ADDR_W and above have no effect.
- R6: Any other opcode leaves both outputs disabled until deselection. The next command after deselection is decoded normally.
- R7: Raising `spi_cs_n` in the middle of a command aborts it and disables the outputs. A following command is decoded from its first bit.
- R8: Both clock polarities are accepted. The serial clock may idle low (mode 0) or high (mode 3) while deselected, and a falling edge before the first rising edge has no effect.
- R9: When `pre_we` is 1, `pre_data` is written to byte `pre_addr` at the system clock edge, and later serial reads of that byte return the new value.
- R10: Data outputs change only in response to a falling serial clock edge. They change within SYNC_STAGES+2 system clocks of that edge and hold through the following high phase.
- R11: If deselection and a falling serial clock edge reach the device in the same system clock, the abort wins. Both enables go low, and the data outputs keep the bit they had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low device select |
| io0_i | input | 1 | Data line 0 input (serial in for single-line phases) |
| io0_o | output | 1 | Data line 0 output value |
| io0_oe | output | 1 | Data line 0 output enable |
| io1_i | input | 1 | Data line 1 input (high bit in dual input phases) |
| io1_o | output | 1 | Data line 1 output value (serial out) |
| io1_oe | output | 1 | Data line 1 output enable |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
Two events can land in the same system clock: deselection and a falling serial clock edge during the data phase. The bench provokes this by lowering the serial clock and raising the select in the same system clock, right after a byte boundary. The byte that follows is chosen so that honouring the edge would visibly change the data pins. The check then requires both enables low and the last driven bits unchanged. The same collision is also watched by a property on the sequencer. Byte boundaries that coincide with the address wrap are driven through reads that start near the top of the array.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_WAIT,
    PH_DATA,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    CM_SINGLE,
    CM_DUAL_OUT,
    CM_DUAL_IO
  } cmd_t;

  localparam logic [7:0]  OPC_READ   = 8'h03;
  localparam logic [7:0]  OPC_DOUT   = 8'h3B;
  localparam logic [7:0]  OPC_DIO    = 8'hBB;
  localparam int unsigned OPC_BITS   = 8;
  localparam int unsigned ADDR_BITS  = 24;
  localparam int unsigned DUMMY_CLKS = 8;
  localparam int unsigned MODE_CLKS  = 4;

endpackage

// File: rtl/fsp_pin_sync.sv
module fsp_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/fsp_edge_det.sv
module fsp_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/fsp_byte_ram.sv
module fsp_byte_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fsp_cmd_seq.sv
module fsp_cmd_seq
  import fsp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              rise,
  input  logic              fall,
  input  logic              d0,
  input  logic              d1,
  input  logic [7:0]        ram_q,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              io0_o,
  output logic              io0_oe,
  output logic              io1_o,
  output logic              io1_oe
);

  localparam int CNT_W      = $clog2(ADDR_BITS);
  localparam int OPC_LAST   = OPC_BITS - 1;
  localparam int ADDR_LAST1 = ADDR_BITS - 1;
  localparam int ADDR_LAST2 = ADDR_BITS / 2 - 1;
  localparam int DUMMY_LAST = DUMMY_CLKS - 1;
  localparam int MODE_LAST  = MODE_CLKS - 1;

  phase_t                 phase;
  cmd_t                   cmd;
  logic [CNT_W-1:0]       cnt;
  logic [ADDR_BITS-1:0]   sh_in;
  logic [ADDR_BITS-1:0]   sh_nxt;
  logic [ADDR_W-1:0]      addr;
  logic [2:0]             bitpos;
  logic [7:0]             out_byte;
  logic [7:0]             cur_byte;
  logic                   dual;
  logic                   addr_dual;
  logic                   addr_last;
  logic                   wait_last;
  logic                   byte_last;

  assign dual      = (cmd != CM_SINGLE);
  assign addr_dual = (cmd == CM_DUAL_IO);
  assign ram_addr  = addr;

  always_comb begin
    if (phase == PH_ADDR && addr_dual) sh_nxt = {sh_in[ADDR_BITS-3:0], d1, d0};
    else                               sh_nxt = {sh_in[ADDR_BITS-2:0], d0};
  end

  assign addr_last = addr_dual ? (cnt == CNT_W'(ADDR_LAST2)) : (cnt == CNT_W'(ADDR_LAST1));
  assign wait_last = addr_dual ? (cnt == CNT_W'(MODE_LAST))  : (cnt == CNT_W'(DUMMY_LAST));
  assign cur_byte  = (bitpos == 3'd0) ? ram_q : out_byte;
  assign byte_last = dual ? (bitpos == 3'd3) : (bitpos == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_OPC;
      cmd      <= CM_SINGLE;
      cnt      <= '0;
      sh_in    <= '0;
      addr     <= '0;
      bitpos   <= '0;
      out_byte <= '0;
      io0_o    <= 1'b0;
      io1_o    <= 1'b0;
      io0_oe   <= 1'b0;
      io1_oe   <= 1'b0;
    end else if (cs_hi) begin
      phase  <= PH_OPC;
      cnt    <= '0;
      bitpos <= '0;
      io0_oe <= 1'b0;
      io1_oe <= 1'b0;
    end else begin
      if (rise) begin
        case (phase)
          PH_OPC: begin
            sh_in <= sh_nxt;
            if (cnt == CNT_W'(OPC_LAST)) begin
              cnt <= '0;
              case (sh_nxt[7:0])
                OPC_READ: begin cmd <= CM_SINGLE;   phase <= PH_ADDR; end
                OPC_DOUT: begin cmd <= CM_DUAL_OUT; phase <= PH_ADDR; end
                OPC_DIO:  begin cmd <= CM_DUAL_IO;  phase <= PH_ADDR; end
                default:  phase <= PH_SKIP;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            sh_in <= sh_nxt;
            if (addr_last) begin
              addr  <= sh_nxt[ADDR_W-1:0];
              cnt   <= '0;
              phase <= (cmd == CM_SINGLE) ? PH_DATA : PH_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_WAIT: begin
            if (wait_last) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (fall && phase == PH_DATA) begin
        io1_o  <= cur_byte[7];
        io0_o  <= dual ? cur_byte[6] : 1'b0;
        io1_oe <= 1'b1;
        io0_oe <= dual;
        if (dual) out_byte <= {cur_byte[5:0], 2'b00};
        else      out_byte <= {cur_byte[6:0], 1'b0};
        if (byte_last) begin
          bitpos <= '0;
          addr   <= addr + 1'b1;
        end else begin
          bitpos <= bitpos + 1'b1;
        end
      end
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (!io0_oe && !io1_oe && phase == PH_OPC));

  assert_lane_pair_R2: assert property (@(posedge clk) disable iff (rst)
    io0_oe |-> io1_oe);

  assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT) |-> (!io0_oe && !io1_oe));

  assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> (!io0_oe && !io1_oe));

  assert_fall_only_R10: assert property (@(posedge clk) disable iff (rst)
    !fall |=> ($stable(io1_o) && $stable(io0_o)));

  assert_abort_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (cs_hi && fall) |=> (!io1_oe && !io0_oe && $stable(io1_o) && $stable(io0_o)));

endmodule

// File: rtl/fsp_flash_if.sv
module fsp_flash_if #(
  parameter int ADDR_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              io0_i,
  output logic              io0_o,
  output logic              io0_oe,
  input  logic              io1_i,
  output logic              io1_o,
  output logic              io1_oe,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [7:0]        pre_data
);

  localparam int PIN_W = 4;

  logic [PIN_W-1:0]  pins_raw;
  logic [PIN_W-1:0]  pins_s;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  assign pins_raw = {spi_cs_n, spi_sclk, io1_i, io0_i};

  fsp_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1000)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_raw),
    .dout (pins_s)
  );

  fsp_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pins_s[2]),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  fsp_byte_ram #(
    .AW (ADDR_W)
  ) u_ram (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  fsp_cmd_seq #(
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cs_hi    (pins_s[3]),
    .rise     (sclk_rise),
    .fall     (sclk_fall),
    .d0       (pins_s[0]),
    .d1       (pins_s[1]),
    .ram_q    (rd_data),
    .ram_addr (rd_addr),
    .io0_o    (io0_o),
    .io0_oe   (io0_oe),
    .io1_o    (io1_o),
    .io1_oe   (io1_oe)
  );

endmodule

// File: tb/fsp_flash_if_bench.sv
`timescale 1ns/1ps
module fsp_flash_if_bench;

  localparam int AW   = 8;
  localparam int SYNC = 2;
  localparam int HALF = 6;
  localparam int NB   = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic h0 = 1'b0;
  logic h1 = 1'b0;
  logic o0, o1, oe0, oe1;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [NB];

  always #2.5 clk = ~clk;

  fsp_flash_if #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) u_fsp_flash_if (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .io0_i(h0), .io0_o(o0), .io0_oe(oe0),
    .io1_i(h1), .io1_o(o1), .io1_oe(oe1),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input int a, input logic [7:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a[AW-1:0]; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
    exp_mem[a] = d;
  endtask

  task automatic spi_begin(input bit mode3);
    sclk = mode3;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_end(input bit mode3);
    if (!mode3) sclk = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF * 2);
    chk(!oe0 && !oe1, "R1 enables after deselect", {oe1, oe0}, 0);
  endtask

  task automatic cyc_in(input bit b1, input bit b0);
    sclk = 1'b0; h1 = b1; h0 = b0;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic cyc_out(output logic [1:0] d, output logic [1:0] oe, output bit stable);
    sclk = 1'b0;
    wait_clk(HALF);
    d = {o1, o0};
    oe = {oe1, oe0};
    sclk = 1'b1;
    wait_clk(HALF);
    stable = ({o1, o0} == d);
  endtask

  task automatic send_head(input logic [7:0] opc, input logic [23:0] a24);
    logic [7:0] mb;
    mb = 8'hA5;
    for (int i = 7; i >= 0; i--) cyc_in(1'b0, opc[i]);
    if (opc == 8'hBB) begin
      for (int k = 0; k < 12; k++) cyc_in(a24[23 - 2*k], a24[22 - 2*k]);
      for (int k = 0; k < 4; k++) cyc_in(mb[7 - 2*k], mb[6 - 2*k]);
      chk(!oe0 && !oe1, "R4 enables low during dual input", {oe1, oe0}, 0);
    end else begin
      for (int i = 23; i >= 0; i--) cyc_in(1'b0, a24[i]);
      if (opc == 8'h3B) begin
        for (int k = 0; k < 8; k++) cyc_in(1'b0, 1'b0);
        chk(!oe0 && !oe1, "R3 enables low after dummy clocks", {oe1, oe0}, 0);
      end
    end
  endtask

  task automatic get_byte(input bit dual, output logic [7:0] got,
                          output logic [1:0] oe, output bit stable_all);
    logic [1:0] d;
    bit st;
    got = '0;
    stable_all = 1'b1;
    if (dual) begin
      for (int k = 0; k < 4; k++) begin
        cyc_out(d, oe, st);
        got = {got[5:0], d};
        stable_all &= st;
      end
    end else begin
      for (int k = 0; k < 8; k++) begin
        cyc_out(d, oe, st);
        got = {got[6:0], d[1]};
        stable_all &= st;
      end
    end
  endtask

  task automatic do_read(input logic [7:0] opc, input int addr, input int n,
                         input bit mode3, input string req);
    logic [7:0] got;
    logic [1:0] oe;
    bit stable_all;
    bit dual;
    int idx;
    dual = (opc != 8'h03);
    spi_begin(mode3);
    send_head(opc, addr[23:0]);
    for (int b = 0; b < n; b++) begin
      get_byte(dual, got, oe, stable_all);
      idx = (addr + b) & (NB - 1);
      chk(got == exp_mem[idx], req, got, exp_mem[idx]);
      chk(oe == (dual ? 2'b11 : 2'b10), {req, " R2 enable pattern"}, oe, dual ? 3 : 2);
      chk(stable_all, "R10 data held through high phase", 0, 1);
    end
    spi_end(mode3);
  endtask

  initial begin
    logic [1:0] d;
    logic [1:0] oe;
    logic [7:0] got;
    bit st;
    bit quiet;
    int a;

    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    chk(!oe0 && !oe1, "R1 reset state", {oe1, oe0}, 0);

    for (int i = 0; i < NB; i++) preload(i, 8'((i * 37 + 11) & 255));

    // R2 R3 R4 R8: sweep of start addresses, both clock polarities
    for (int k = 0; k < 16; k++) begin
      a = k * 17;
      do_read(8'h03, a, 3, k[0], "R2 single read");
      do_read(8'h3B, a, 3, !k[0], "R3 dual output read");
      do_read(8'hBB, a, 3, k[0], "R4 dual io read");
    end

    // R5: wrap at top of array and upper address bits ignored
    do_read(8'h03, 32'h00AB12FE, 4, 1'b0, "R5 wrap single");
    do_read(8'hBB, 32'h00FF00FF, 3, 1'b1, "R5 wrap dual io");
    do_read(8'h3B, 32'h00C0FFFD, 4, 1'b0, "R5 wrap dual output");

    // R6: unknown opcode stays quiet, next command works
    spi_begin(1'b0);
    for (int i = 7; i >= 0; i--) cyc_in(1'b0, 8'h9F >> i);
    quiet = 1'b1;
    for (int k = 0; k < 32; k++) begin
      cyc_out(d, oe, st);
      if (oe != 2'b00) quiet = 1'b0;
    end
    chk(quiet, "R6 unknown opcode drives nothing", !quiet, 0);
    spi_end(1'b0);
    do_read(8'h03, 8'h21, 2, 1'b0, "R6 command after unknown opcode");

    // R7: abort in the middle of a data byte
    spi_begin(1'b0);
    send_head(8'h03, 24'h000040);
    for (int k = 0; k < 3; k++) cyc_out(d, oe, st);
    chk(oe == 2'b10, "R7 driving before abort", oe, 2);
    cs_n = 1'b1;
    wait_clk(SYNC + 3);
    chk(!oe0 && !oe1, "R7 abort releases outputs", {oe1, oe0}, 0);
    sclk = 1'b0;
    wait_clk(HALF);
    do_read(8'h03, 8'h41, 2, 1'b0, "R7 command after abort");

    // R8: explicit mode 3 read
    do_read(8'h3B, 8'h80, 2, 1'b1, "R8 mode 3 read");

    // R9: preload rewrite then read
    preload(8'h30, 8'h00);
    preload(8'h31, 8'hFF);
    preload(8'h90, 8'h5A);
    do_read(8'hBB, 8'h30, 2, 1'b0, "R9 rewritten bytes");
    do_read(8'h03, 8'h90, 1, 1'b1, "R9 rewritten byte single");

    // R11: deselect and falling edge in the same system clock
    spi_begin(1'b0);
    send_head(8'hBB, 24'h000030);
    get_byte(1'b1, got, oe, st);
    chk(got == 8'h00 && oe == 2'b11, "R11 byte before collision", got, 0);
    @(negedge clk);
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(SYNC + 4);
    chk(!oe0 && !oe1, "R11 abort wins enables", {oe1, oe0}, 0);
    chk({o1, o0} == 2'b00, "R11 data pins not advanced", {o1, o0}, 0);
    wait_clk(HALF);
    do_read(8'h03, 8'h31, 1, 1'b0, "R11 recovery read");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule